// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting timer channel. A configuration strobe selects one of six counting behaviours and picks binary or four-digit decimal (BCD) arithmetic. A load strobe supplies the initial count. Counting advances only on clock cycles where the counter enable `cnt_en` is high, so a slower counting clock can be derived from the system clock. The `gate` input either pauses counting or retriggers it, depending on the behaviour selected.

The channel drives a single `out` pin and shows its live count element on `count`, so a surrounding register file can latch the count and read it back. All control pins are plain one-cycle strobes. No data stream crosses the edge of the block, so there is no valid/ready handshake.

Priorities in one clock cycle, from highest to lowest: configuration write, count load, gate trigger, count tick. A tick happens on a cycle with `cnt_en` high, provided the channel is running. In the gate-paused behaviours, `gate` must also be high.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is 0, `count` is 0 and the channel does not count until it is configured and loaded.
- R2: A loaded value of 0 acts as the largest count: 65536 ticks in binary and 10000 ticks in BCD.
- R3: In behaviours 0, 1, 4 and 5 the count keeps going past zero. It wraps from 0000 to FFFF hex in binary and from 0000 to 9999 in BCD. In BCD every nibble is a decimal digit, and a digit borrows from the next one (0100 becomes 0099).
- R4: Behaviour 0 (code 0), terminal-count flag:
  - a configuration write or a load drives `out` to 0;
  - the load takes effect in the same cycle;
  - `out` rises on the N-th tick after the load and then stays high;
  - `gate` low freezes the count;
  - a load while counting restarts the count at once.
- R5: Behaviour 1 (code 1), retriggerable one-shot:
  - `out` is 1 after configuration;
  - a rising edge on `gate` after a load sets the count to N and drives `out` to 0;
  - `out` returns to 1 on the N-th tick;
  - a retrigger while counting reloads N and `out` stays 0;
  - before the first trigger the count does not move.
- R6: Behaviour 2 (code 2), rate generator:
  - after the load, `out` is 0;
  - `out` is 1 for exactly one tick period on every N-th tick;
  - at that tick the count reloads N;
  - otherwise the count is N minus (ticks mod N).
- R7: Behaviour 3 (code 3), square wave:
  - `out` is 1 after the load;
  - during each period of N ticks, `out` is high for the first (N+1)/2 ticks and low for the remaining N/2 ticks;
  - the count element steps down by two, or by one when it is odd.
- R8: Behaviours 4 (code 4, software strobe) and 5 (code 5, gate-triggered strobe):
  - `out` is 0 except for one tick period starting at the N-th tick, and this pulse happens once per load or trigger;
  - behaviour 4 starts on the load;
  - behaviour 5 waits for a rising edge on `gate`.
- R9: Configuration codes 6 and 7 select behaviours 2 and 3 respectively.
- R10: In behaviours 2 and 3, a load while running only replaces the reload value, which is used at the next reload point. A rising edge on `gate` restarts the count from the reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count tick enable, one system cycle per counting clock |
| gate | input | 1 | Gate level; pauses or retriggers depending on behaviour |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Behaviour code 0..7 |
| cfg_bcd | input | 1 | 1 selects four-digit BCD counting |
| load_stb | input | 1 | Count load strobe |
| load_val | input | 16 | Initial count, binary or BCD |
| out | output | 1 | Channel output |
| count | output | 16 | Live count element |

## Verification
The assertions assume that `load_val` holds legal BCD digits whenever BCD counting is selected. They also assume that counts of at least 2 are used in behaviours 2 and 3, because a count of 1 has no meaningful period there. They further rely on the strobe priority order, so each property excludes configuration writes, loads and gate triggers in the cycle it examines. The stimulus changes inputs only on the falling clock edge and uses only valid BCD values. It loads counts of 2 or more in the periodic behaviours, and it sweeps small counts tick by tick, so every edge of `out` is compared against the period arithmetic.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TC_FLAG   = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } pit_mode_e;

  // codes 6 and 7 alias the periodic behaviours
  function automatic pit_mode_e pit_norm_mode(input logic [2:0] code);
    logic [2:0] c;
    c = (code[2:1] == 2'b11) ? {1'b0, code[1:0]} : code;
    return pit_mode_e'(c);
  endfunction

endpackage

// File: rtl/pit_dec.sv
module pit_dec #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  input  logic         two,
  output logic [W-1:0] res
);

  logic [W-1:0] bin_res;
  logic [W-1:0] dec_res;
  logic [3:0]   brw;
  logic [3:0]   dig;

  assign bin_res = val - {{(W-2){1'b0}}, two, ~two};

  always_comb begin
    brw     = {2'b00, two, ~two};
    dig     = 4'd0;
    dec_res = '0;
    for (int i = 0; i < DIGITS; i++) begin
      dig = val[4*i +: 4];
      if (dig < brw) begin
        dec_res[4*i +: 4] = dig + 4'd10 - brw;
        brw = 4'd1;
      end else begin
        dec_res[4*i +: 4] = dig - brw;
        brw = 4'd0;
      end
    end
  end

  assign res = bcd ? dec_res : bin_res;

endmodule

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);

  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign rise = gate & ~gate_q;

endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int DIGITS = 4,
  localparam int CNT_W = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             gate,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_bcd,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  output logic             out,
  output logic [CNT_W-1:0] count
);
  import pit_pkg::*;

  pit_mode_e        mode_q;
  pit_mode_e        new_mode;
  logic             bcd_q;
  logic [CNT_W-1:0] cr_q;
  logic [CNT_W-1:0] ce_q;
  logic [CNT_W-1:0] ce_nxt;
  logic             run_q, armed_q, done_q, out_q;
  logic             gate_rise, level_gated, tick, step_two, at_zero;

  pit_gate_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .gate (gate),
    .rise (gate_rise)
  );

  assign step_two = (mode_q == M_SQUARE) && !ce_q[0];

  pit_dec #(.DIGITS(DIGITS)) u_dec (
    .val(ce_q),
    .bcd(bcd_q),
    .two(step_two),
    .res(ce_nxt)
  );

  assign new_mode    = pit_norm_mode(cfg_mode);
  assign level_gated = (mode_q == M_TC_FLAG) || (mode_q == M_RATE) ||
                       (mode_q == M_SQUARE)  || (mode_q == M_SW_STROBE);
  assign tick        = cnt_en && run_q && (!level_gated || gate);
  assign at_zero     = (ce_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_TC_FLAG;
      bcd_q   <= 1'b0;
      cr_q    <= '0;
      ce_q    <= '0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      out_q   <= 1'b0;
    end else if (cfg_wr) begin
      mode_q  <= new_mode;
      bcd_q   <= cfg_bcd;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      out_q   <= (new_mode == M_ONESHOT) || (new_mode == M_SQUARE);
    end else if (load_stb) begin
      cr_q    <= load_val;
      armed_q <= 1'b1;
      case (mode_q)
        M_TC_FLAG, M_SW_STROBE: begin
          ce_q   <= load_val;
          run_q  <= 1'b1;
          done_q <= 1'b0;
          out_q  <= 1'b0;
        end
        M_RATE, M_SQUARE: begin
          if (!run_q) begin
            ce_q  <= load_val;
            run_q <= 1'b1;
            out_q <= (mode_q == M_SQUARE);
          end
        end
        default: ;
      endcase
    end else if (gate_rise && armed_q &&
                 (mode_q != M_TC_FLAG) && (mode_q != M_SW_STROBE)) begin
      ce_q   <= cr_q;
      run_q  <= 1'b1;
      done_q <= 1'b0;
      out_q  <= (mode_q == M_SQUARE);
    end else if (tick) begin
      case (mode_q)
        M_TC_FLAG, M_ONESHOT: begin
          ce_q <= ce_nxt;
          if (at_zero && !done_q) begin
            done_q <= 1'b1;
            out_q  <= 1'b1;
          end
        end
        M_SW_STROBE, M_HW_STROBE: begin
          ce_q  <= ce_nxt;
          out_q <= at_zero && !done_q;
          if (at_zero) done_q <= 1'b1;
        end
        M_RATE: begin
          if (ce_q == CNT_W'(1)) begin
            ce_q  <= cr_q;
            out_q <= 1'b1;
          end else begin
            ce_q  <= ce_nxt;
            out_q <= 1'b0;
          end
        end
        M_SQUARE: begin
          if (ce_q == CNT_W'(2)) begin
            out_q <= !out_q;
            ce_q  <= out_q ? {cr_q[CNT_W-1:1], 1'b0} : cr_q;
          end else begin
            ce_q <= ce_nxt;
          end
        end
        default: ;
      endcase
    end
  end

  assign out   = out_q;
  assign count = ce_q;

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              gate,
  input logic              cfg_wr,
  input logic [2:0]        cfg_mode,
  input logic              load_stb,
  input logic              out,
  input logic [W-1:0]      count,
  input pit_pkg::pit_mode_e mode_q,
  input logic              run_q,
  input logic              trig,
  input logic [W-1:0]      cr_q
);
  import pit_pkg::*;

  logic quiet;
  assign quiet = !cfg_wr && !load_stb && !trig;

  p_cfg_out_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_mode == 3'd0) |=> !out);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && quiet) |=> $stable(count));

  p_gate_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !gate && (mode_q == M_TC_FLAG || mode_q == M_SW_STROBE))
      |=> $stable(count));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && out && cnt_en &&
     (mode_q == M_HW_STROBE || (mode_q == M_SW_STROBE && gate))) |=> !out);

  p_rate_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && mode_q == M_RATE && run_q && cnt_en && gate && count == W'(1))
      |=> (out && count == $past(cr_q)));

endmodule

bind pit_channel pit_channel_chk #(.W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_en  (cnt_en),
  .gate    (gate),
  .cfg_wr  (cfg_wr),
  .cfg_mode(cfg_mode),
  .load_stb(load_stb),
  .out     (out),
  .count   (count),
  .mode_q  (mode_q),
  .run_q   (run_q),
  .trig    (gate_rise),
  .cr_q    (cr_q)
);

// File: tb/pit_channel_test.sv
module pit_channel_test;

  logic        clk = 1'b0;
  logic        rst_n, cnt_en, gate, cfg_wr, cfg_bcd, load_stb;
  logic [2:0]  cfg_mode;
  logic [15:0] load_val;
  logic        out;
  logic [15:0] count;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pit_channel uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
    .load_stb(load_stb), .load_val(load_val), .out(out), .count(count)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int to_bcd(input int v);
    return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 +
           ((v / 10) % 10) * 16 + (v % 10);
  endfunction

  task automatic cfg(input int m, input bit b);
    cfg_wr = 1'b1; cfg_mode = 3'(m); cfg_bcd = b;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic load(input int v);
    load_stb = 1'b1; load_val = 16'(v);
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  task automatic set_gate(input bit v);
    gate = v;
    @(negedge clk);
  endtask

  task automatic pulse_gate();
    set_gate(1'b0);
    set_gate(1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int hold;
    rst_n = 1'b0; cnt_en = 1'b0; gate = 1'b1; cfg_wr = 1'b0;
    cfg_mode = 3'd0; cfg_bcd = 1'b0; load_stb = 1'b0; load_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out", int'(out), 0);
    chk("R1 count", int'(count), 0);
    run(3);
    chk("R1 idle count", int'(count), 0);

    // R4 / R3: behaviour 0 sweep over small counts
    for (int n = 1; n <= 5; n++) begin
      cfg(0, 0);
      chk("R4 out after cfg", int'(out), 0);
      load(n);
      for (int k = 1; k <= n + 2; k++) begin
        run(1);
        chk("R4 out", int'(out), (k >= n) ? 1 : 0);
        chk("R3 count", int'(count), (n - k) & 16'hFFFF);
      end
    end
    cfg(0, 0); load(5); run(2);
    set_gate(1'b0); run(3);
    chk("R4 gate freeze", int'(count), 3);
    set_gate(1'b1); run(3);
    chk("R4 terminal", int'(out), 1);
    load(7);
    chk("R4 reload out", int'(out), 0);
    chk("R4 reload count", int'(count), 7);

    // R2 zero count, binary and BCD; R3 wrap and digit borrow
    cfg(0, 0); load(0); run(65535);
    chk("R2 bin before", int'(out), 0);
    chk("R2 bin count", int'(count), 1);
    run(1);
    chk("R2 bin terminal", int'(out), 1);
    run(1);
    chk("R3 bin wrap", int'(count), 16'hFFFF);
    cfg(0, 1); load(0); run(9999);
    chk("R2 bcd before", int'(out), 0);
    chk("R2 bcd count", int'(count), 1);
    run(1);
    chk("R2 bcd terminal", int'(out), 1);
    run(1);
    chk("R3 bcd wrap", int'(count), 16'h9999);
    cfg(0, 1); load(16'h0100); run(1);
    chk("R3 bcd borrow", int'(count), 16'h0099);
    for (int k = 1; k <= 120; k++) begin
      run(1);
      chk("R3 bcd digits", int'(count), to_bcd((99 - k + 10000) % 10000));
    end

    // R8 software strobe
    cfg(4, 0); load(3);
    for (int k = 1; k <= 6; k++) begin
      run(1);
      chk("R8 sw strobe", int'(out), (k == 3) ? 1 : 0);
    end
    // R8 gate strobe, waits for trigger
    cfg(5, 0); load(4);
    hold = int'(count);
    run(2);
    chk("R8 waits trigger", int'(count), hold);
    pulse_gate();
    chk("R8 trig count", int'(count), 4);
    for (int k = 1; k <= 6; k++) begin
      run(1);
      chk("R8 hw strobe", int'(out), (k == 4) ? 1 : 0);
    end

    // R5 one-shot with retrigger
    cfg(1, 0);
    chk("R5 idle out", int'(out), 1);
    load(4);
    hold = int'(count);
    run(2);
    chk("R5 no count before trigger", int'(count), hold);
    pulse_gate();
    chk("R5 trig out", int'(out), 0);
    chk("R5 trig count", int'(count), 4);
    run(2);
    chk("R5 mid count", int'(count), 2);
    pulse_gate();
    chk("R5 retrig count", int'(count), 4);
    chk("R5 retrig out", int'(out), 0);
    for (int k = 1; k <= 5; k++) begin
      run(1);
      chk("R5 out", int'(out), (k >= 4) ? 1 : 0);
    end

    // R6 rate generator sweep
    for (int n = 2; n <= 5; n++) begin
      cfg(2, 0); load(n);
      chk("R6 start out", int'(out), 0);
      for (int k = 1; k <= 3 * n; k++) begin
        run(1);
        chk("R6 out", int'(out), (k % n == 0) ? 1 : 0);
        chk("R6 count", int'(count), n - (k % n));
      end
    end
    // R10 deferred reload value and gate restart
    cfg(2, 0); load(4); run(1); load(6);
    chk("R10 deferred", int'(count), 3);
    run(2);
    chk("R10 before reload", int'(count), 1);
    run(1);
    chk("R10 reload out", int'(out), 1);
    chk("R10 new value", int'(count), 6);
    run(2);
    pulse_gate();
    chk("R10 gate restart", int'(count), 6);

    // R7 square wave sweep, binary then BCD
    for (int n = 2; n <= 7; n++) begin
      cfg(3, 0); load(n);
      chk("R7 start out", int'(out), 1);
      for (int k = 1; k <= 2 * n; k++) begin
        run(1);
        chk("R7 out", int'(out), ((k % n) < (n + 1) / 2) ? 1 : 0);
      end
    end
    cfg(3, 1); load(16'h0015);
    for (int k = 1; k <= 30; k++) begin
      run(1);
      chk("R7 bcd out", int'(out), ((k % 15) < 8) ? 1 : 0);
    end

    // R9 alias codes
    cfg(6, 0); load(3);
    for (int k = 1; k <= 6; k++) begin
      run(1);
      chk("R9 code6", int'(out), (k % 3 == 0) ? 1 : 0);
    end
    cfg(7, 0); load(4);
    chk("R9 code7 start", int'(out), 1);
    for (int k = 1; k <= 8; k++) begin
      run(1);
      chk("R9 code7", int'(out), ((k % 4) < 2) ? 1 : 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule